// File: doc/BRIEF.md
# System Control Register Bank

This block holds the memory-system control state of a processor core. The core reaches it with register-transfer commands: a read strobe or a write strobe, together with a 4-bit primary register number, a 4-bit secondary number and a 3-bit opcode2 selector. The bank stores these registers:

- the control word, plus an auxiliary word and a coprocessor access word;
- two translation table base words and a 3-bit table split field;
- the domain access word;
- the data fault status and the fault address;
- the process, context and thread identifiers.

Reads also return the core identity and a constant cache-type word. The stored control, table base, split, domain and context values are driven straight out to a translation table walker.

Each command is handled in one cycle. A small state machine then reports the result during the following cycle. It has four states:

- `ST_IDLE`: no command was taken.
- `ST_READ`: read data is valid.
- `ST_WACK`: a write was accepted.
- `ST_WERR`: a write was refused.

From any state the machine moves as follows:

- to `ST_WERR` on a write that selects nothing writable;
- to `ST_WACK` on a write that selects something writable;
- to `ST_READ` on a read without a write;
- otherwise back to `ST_IDLE`.

Cache and TLB maintenance commands are acknowledged and change nothing.

Primary register numbers used by the decode:

| Primary number | Register |
|---|---|
| 0 | identity |
| 1 | control |
| 2 | table base |
| 3 | domain |
| 5 | fault status |
| 6 | fault address |
| 7 | cache maintenance |
| 8 | TLB maintenance |
| 9 | cache lockdown |
| 10 | TLB lockdown |
| 13 | identifiers |

Top module: `sysctl_regbank`

## Requirements
- R1: After reset the registers hold these values. Control is 0x00050078. Both table bases and the domain word are 0xDEADC0DE. Auxiliary, coprocessor access, split, both fault status values, fault address and the three identifiers are 0.
- R2: A write to primary 1 with opcode2 0 stores (value | 0x00050078) & 0xFFFFFBFF. That forces bits 3 to 6, 16 and 18 high and bit 10 low. A read of primary 1 with opcode2 0 returns the stored word with the same forcing applied.
- R3: On primary 1, opcode2 1 writes and reads the auxiliary word, and opcode2 2 writes and reads the coprocessor access word. Both are 32 bits.
- R4: On primary 2, opcode2 0 selects table base 0, opcode2 1 selects table base 1, and opcode2 2 selects the split field. The split field keeps only value[2:0] and reads back zero-extended.
- R5: Primary 3 (domain) and primary 6 (fault address) store and return all 32 bits for every opcode2 value.
- R6: On primary 5, a write with opcode2 0 keeps value[7:0] as the data fault status. A read with opcode2 0 returns that byte zero-extended. A read with opcode2 1 returns the instruction fault status, which has no write path and stays 0.
- R7: Primary 0 is read-only. A read with opcode2 0 returns the core identity. A read with opcode2 1 returns 0x0D172172.
- R8: On primary 13, opcode2 0, 1 and 3 select the process, context and thread identifiers, each 32 bits.
- R9: A read returns 0 in two cases: an unimplemented primary number, or an implemented primary with an opcode2 that selects nothing. Primaries 7 to 10 also read as 0.
- R10: Some writes select nothing writable. These are a write with an unsupported opcode2, a write to primary 0, a write with opcode2 1 on primary 5, and a write to an unimplemented primary. Such a write leaves every register unchanged and raises wr_err for exactly one cycle.
- R11: Maintenance writes are acknowledged with a one-cycle wr_ack and change no register. This covers primaries 7, 9 and 10 with any opcode2, and primary 8 with secondary 5, 6 or 7 and opcode2 0 to 2. Any other write to primary 8 is refused as in R10.
- R12: rdata and rvalid become valid in the cycle after the read strobe, and rvalid lasts one cycle. wr_ack and wr_err appear in the cycle after the write strobe. At most one of rvalid, wr_ack and wr_err is high. If both strobes are high together, only the write is performed and rvalid stays low.
- R13: The walker outputs show the stored control, table base 0, table base 1, split, domain and context values from the cycle after the write that changed them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | Read strobe, one command per cycle |
| wr_en | input | 1 | Write strobe, takes priority over rd_en |
| crn | input | 4 | Primary register number |
| crm | input | 4 | Secondary register number |
| op2 | input | 3 | Opcode2 selector |
| wdata | input | 32 | Write value |
| rdata | output | 32 | Registered read data |
| rvalid | output | 1 | Read data valid, one cycle |
| wr_ack | output | 1 | Write accepted, one cycle |
| wr_err | output | 1 | Write refused, one cycle |
| ctrl_o | output | 32 | Stored control word |
| ttb0_o | output | 32 | Table base 0 |
| ttb1_o | output | 32 | Table base 1 |
| split_o | output | 3 | Table split field |
| domain_o | output | 32 | Domain access word |
| ctx_id_o | output | 32 | Context identifier |

## Verification
A register that takes the wrong value is visible on the read port one cycle after the next read of it. For the walker-facing registers it is also visible on the dedicated outputs one cycle after the write. A wrong decode path shows up as the wrong register changing. Because every register is read back after every one of the 128 primary and opcode2 write combinations, such a fault appears within one sweep step. A stuck or skipped state in the response machine shows within a single command, as a missing, doubled or wrong strobe among rvalid, wr_ack and wr_err.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int DW      = 32;
    localparam int SPLIT_W = 3;
    localparam int FSR_W   = 8;
    localparam int NUM_W   = 4;
    localparam int OP_W    = 3;

    // Primary register numbers (decoded by the core, so fixed)
    localparam logic [NUM_W-1:0] CRN_IDENT_HW = 4'd0;
    localparam logic [NUM_W-1:0] CRN_CTRL     = 4'd1;
    localparam logic [NUM_W-1:0] CRN_TBASE    = 4'd2;
    localparam logic [NUM_W-1:0] CRN_DOMAIN   = 4'd3;
    localparam logic [NUM_W-1:0] CRN_FSTAT    = 4'd5;
    localparam logic [NUM_W-1:0] CRN_FADDR    = 4'd6;
    localparam logic [NUM_W-1:0] CRN_CMAINT   = 4'd7;
    localparam logic [NUM_W-1:0] CRN_TMAINT   = 4'd8;
    localparam logic [NUM_W-1:0] CRN_CLOCK    = 4'd9;
    localparam logic [NUM_W-1:0] CRN_TLOCK    = 4'd10;
    localparam logic [NUM_W-1:0] CRN_IDS      = 4'd13;

    typedef enum logic [4:0] {
        SEL_NONE,
        SEL_CORE_ID,
        SEL_CACHE_TYPE,
        SEL_CTRL,
        SEL_AUX,
        SEL_CPACC,
        SEL_TTB0,
        SEL_TTB1,
        SEL_SPLIT,
        SEL_DOMAIN,
        SEL_DFSR,
        SEL_IFSR,
        SEL_FAR,
        SEL_PID,
        SEL_CTX,
        SEL_THR,
        SEL_MAINT
    } sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WACK,
        ST_WERR
    } state_e;

    typedef struct packed {
        logic [DW-1:0]      ctrl;
        logic [DW-1:0]      aux;
        logic [DW-1:0]      cpacc;
        logic [DW-1:0]      ttb0;
        logic [DW-1:0]      ttb1;
        logic [SPLIT_W-1:0] split;
        logic [DW-1:0]      domain;
        logic [FSR_W-1:0]   dfsr;
        logic [FSR_W-1:0]   ifsr;
        logic [DW-1:0]      faddr;
        logic [DW-1:0]      pid;
        logic [DW-1:0]      ctx;
        logic [DW-1:0]      thr;
    } regs_t;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
(
    input  logic [NUM_W-1:0] crn,
    input  logic [NUM_W-1:0] crm,
    input  logic [OP_W-1:0]  op2,
    output sel_e             sel,
    output logic             wr_legal
);

    logic tlb_crm_ok;

    always_comb begin
        tlb_crm_ok = (crm == 4'd5) || (crm == 4'd6) || (crm == 4'd7);
    end

    always_comb begin
        sel = SEL_NONE;
        case (crn)
            CRN_IDENT_HW: begin
                if (op2 == 3'd0)      sel = SEL_CORE_ID;
                else if (op2 == 3'd1) sel = SEL_CACHE_TYPE;
            end
            CRN_CTRL: begin
                if (op2 == 3'd0)      sel = SEL_CTRL;
                else if (op2 == 3'd1) sel = SEL_AUX;
                else if (op2 == 3'd2) sel = SEL_CPACC;
            end
            CRN_TBASE: begin
                if (op2 == 3'd0)      sel = SEL_TTB0;
                else if (op2 == 3'd1) sel = SEL_TTB1;
                else if (op2 == 3'd2) sel = SEL_SPLIT;
            end
            CRN_DOMAIN: sel = SEL_DOMAIN;
            CRN_FSTAT: begin
                if (op2 == 3'd0)      sel = SEL_DFSR;
                else if (op2 == 3'd1) sel = SEL_IFSR;
            end
            CRN_FADDR:  sel = SEL_FAR;
            CRN_CMAINT, CRN_CLOCK, CRN_TLOCK: sel = SEL_MAINT;
            CRN_TMAINT: begin
                if (tlb_crm_ok && (op2 <= 3'd2)) sel = SEL_MAINT;
            end
            CRN_IDS: begin
                if (op2 == 3'd0)      sel = SEL_PID;
                else if (op2 == 3'd1) sel = SEL_CTX;
                else if (op2 == 3'd3) sel = SEL_THR;
            end
            default: sel = SEL_NONE;
        endcase
    end

    // Writable selections: identity, cache type and instruction status are read-only
    always_comb begin
        case (sel)
            SEL_NONE, SEL_CORE_ID, SEL_CACHE_TYPE, SEL_IFSR: wr_legal = 1'b0;
            default:                                         wr_legal = 1'b1;
        endcase
    end

endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
    import sysctl_pkg::*;
#(
    parameter logic [DW-1:0] CTRL_SET = 32'h0005_0078,
    parameter logic [DW-1:0] CTRL_CLR = 32'h0000_0400,
    parameter logic [DW-1:0] BASE_RST = 32'hDEAD_C0DE
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  sel_e          sel,
    input  logic [DW-1:0] wdata,
    output regs_t         regs
);

    localparam logic [DW-1:0] CTRL_RST = CTRL_SET & ~CTRL_CLR;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs.ctrl   <= CTRL_RST;
            regs.aux    <= '0;
            regs.cpacc  <= '0;
            regs.ttb0   <= BASE_RST;
            regs.ttb1   <= BASE_RST;
            regs.split  <= '0;
            regs.domain <= BASE_RST;
            regs.dfsr   <= '0;
            regs.ifsr   <= '0;
            regs.faddr  <= '0;
            regs.pid    <= '0;
            regs.ctx    <= '0;
            regs.thr    <= '0;
        end else if (we) begin
            case (sel)
                SEL_CTRL:   regs.ctrl   <= (wdata | CTRL_SET) & ~CTRL_CLR;
                SEL_AUX:    regs.aux    <= wdata;
                SEL_CPACC:  regs.cpacc  <= wdata;
                SEL_TTB0:   regs.ttb0   <= wdata;
                SEL_TTB1:   regs.ttb1   <= wdata;
                SEL_SPLIT:  regs.split  <= wdata[SPLIT_W-1:0];
                SEL_DOMAIN: regs.domain <= wdata;
                SEL_DFSR:   regs.dfsr   <= wdata[FSR_W-1:0];
                SEL_FAR:    regs.faddr  <= wdata;
                SEL_PID:    regs.pid    <= wdata;
                SEL_CTX:    regs.ctx    <= wdata;
                SEL_THR:    regs.thr    <= wdata;
                default: ;
            endcase
        end
    end

    // R10: with no enabled write, no register moves
    p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> regs == $past(regs));

    // R2: forced control bits hold at all times
    p_ctrl_forced_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((regs.ctrl & CTRL_SET) == CTRL_SET) && ((regs.ctrl & CTRL_CLR) == '0));

    // R6: instruction fault status has no write path
    p_ifsr_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        regs.ifsr == '0);

    // R11: a maintenance write changes no register
    p_maint_noop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_MAINT) |=> regs == $past(regs));

endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
    import sysctl_pkg::*;
#(
    parameter logic [DW-1:0] CORE_ID    = 32'h4A5B_1007,
    parameter logic [DW-1:0] CACHE_TYPE = 32'h0D17_2172,
    parameter logic [DW-1:0] CTRL_SET   = 32'h0005_0078,
    parameter logic [DW-1:0] CTRL_CLR   = 32'h0000_0400
)(
    input  sel_e          sel,
    input  regs_t         regs,
    output logic [DW-1:0] rd_value
);

    always_comb begin
        case (sel)
            SEL_CORE_ID:    rd_value = CORE_ID;
            SEL_CACHE_TYPE: rd_value = CACHE_TYPE;
            SEL_CTRL:       rd_value = (regs.ctrl | CTRL_SET) & ~CTRL_CLR;
            SEL_AUX:        rd_value = regs.aux;
            SEL_CPACC:      rd_value = regs.cpacc;
            SEL_TTB0:       rd_value = regs.ttb0;
            SEL_TTB1:       rd_value = regs.ttb1;
            SEL_SPLIT:      rd_value = {{(DW-SPLIT_W){1'b0}}, regs.split};
            SEL_DOMAIN:     rd_value = regs.domain;
            SEL_DFSR:       rd_value = {{(DW-FSR_W){1'b0}}, regs.dfsr};
            SEL_IFSR:       rd_value = {{(DW-FSR_W){1'b0}}, regs.ifsr};
            SEL_FAR:        rd_value = regs.faddr;
            SEL_PID:        rd_value = regs.pid;
            SEL_CTX:        rd_value = regs.ctx;
            SEL_THR:        rd_value = regs.thr;
            default:        rd_value = '0;
        endcase
    end

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter logic [31:0] CORE_ID    = 32'h4A5B_1007,
    parameter logic [31:0] CACHE_TYPE = 32'h0D17_2172,
    parameter logic [31:0] CTRL_SET   = 32'h0005_0078,
    parameter logic [31:0] CTRL_CLR   = 32'h0000_0400,
    parameter logic [31:0] BASE_RST   = 32'hDEAD_C0DE
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_en,
    input  logic         wr_en,
    input  logic [3:0]   crn,
    input  logic [3:0]   crm,
    input  logic [2:0]   op2,
    input  logic [31:0]  wdata,
    output logic [31:0]  rdata,
    output logic         rvalid,
    output logic         wr_ack,
    output logic         wr_err,
    output logic [31:0]  ctrl_o,
    output logic [31:0]  ttb0_o,
    output logic [31:0]  ttb1_o,
    output logic [2:0]   split_o,
    output logic [31:0]  domain_o,
    output logic [31:0]  ctx_id_o
);

    sel_e          sel;
    logic          wr_legal;
    logic          we;
    logic          rd_fire;
    regs_t         regs;
    logic [DW-1:0] rd_value;
    logic [DW-1:0] rdata_q;
    state_e        state_q;
    state_e        state_d;

    sysctl_decode i_decode (
        .crn      (crn),
        .crm      (crm),
        .op2      (op2),
        .sel      (sel),
        .wr_legal (wr_legal)
    );

    always_comb begin
        we      = wr_en && wr_legal;
        rd_fire = rd_en && !wr_en;
    end

    sysctl_store #(
        .CTRL_SET (CTRL_SET),
        .CTRL_CLR (CTRL_CLR),
        .BASE_RST (BASE_RST)
    ) i_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .sel   (sel),
        .wdata (wdata),
        .regs  (regs)
    );

    sysctl_rdmux #(
        .CORE_ID    (CORE_ID),
        .CACHE_TYPE (CACHE_TYPE),
        .CTRL_SET   (CTRL_SET),
        .CTRL_CLR   (CTRL_CLR)
    ) i_rdmux (
        .sel      (sel),
        .regs     (regs),
        .rd_value (rd_value)
    );

    // Next-state logic: every state leaves on the current command
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_READ, ST_WACK, ST_WERR: begin
                if (wr_en && !wr_legal) state_d = ST_WERR;
                else if (wr_en)         state_d = ST_WACK;
                else if (rd_en)         state_d = ST_READ;
                else                    state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rdata_q <= '0;
        else if (rd_fire) rdata_q <= rd_value;
    end

    // Output logic
    always_comb begin
        rvalid = 1'b0;
        wr_ack = 1'b0;
        wr_err = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_READ: rvalid = 1'b1;
            ST_WACK: wr_ack = 1'b1;
            ST_WERR: wr_err = 1'b1;
        endcase
    end

    always_comb begin
        rdata    = rdata_q;
        ctrl_o   = regs.ctrl;
        ttb0_o   = regs.ttb0;
        ttb1_o   = regs.ttb1;
        split_o  = regs.split;
        domain_o = regs.domain;
        ctx_id_o = regs.ctx;
    end

    // R12: at most one response strobe
    p_one_response_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rvalid, wr_ack, wr_err}));

    // R12: read data valid only after a lone read strobe
    p_rvalid_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(rd_en && !wr_en));

    // R10: refusal follows a write that selected nothing writable
    p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(wr_en && !wr_legal));

    // R9: reads that select nothing return zero
    p_unimpl_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && sel == SEL_NONE) |=> rdata == '0);

    // R13: walker outputs stay put between writes
    p_walker_stable_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_o) && $stable(ttb0_o) && $stable(split_o));

endmodule

// File: tb/test_sysctl_regbank.sv
module test_sysctl_regbank;

    localparam logic [31:0] CORE_ID = 32'h4A5B_1007;
    localparam logic [31:0] CTYPE   = 32'h0D17_2172;
    localparam logic [31:0] FSET    = 32'h0005_0078;
    localparam logic [31:0] FCLR    = 32'h0000_0400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  crn = '0;
    logic [3:0]  crm = '0;
    logic [2:0]  op2 = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rvalid, wr_ack, wr_err;
    logic [31:0] ctrl_o, ttb0_o, ttb1_o, domain_o, ctx_id_o;
    logic [2:0]  split_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // bench model of the registers
    logic [31:0] m_ctrl, m_aux, m_cpacc, m_ttb0, m_ttb1, m_dom, m_far, m_pid, m_ctx, m_thr;
    logic [2:0]  m_split;
    logic [7:0]  m_dfsr;

    always #2 clk = ~clk;

    sysctl_regbank #(.CORE_ID(CORE_ID)) i_sysctl_regbank (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
        .crn(crn), .crm(crm), .op2(op2), .wdata(wdata),
        .rdata(rdata), .rvalid(rvalid), .wr_ack(wr_ack), .wr_err(wr_err),
        .ctrl_o(ctrl_o), .ttb0_o(ttb0_o), .ttb1_o(ttb1_o), .split_o(split_o),
        .domain_o(domain_o), .ctx_id_o(ctx_id_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ctrl = 32'h0005_0078; m_aux = 0; m_cpacc = 0;
        m_ttb0 = 32'hDEAD_C0DE; m_ttb1 = 32'hDEAD_C0DE; m_dom = 32'hDEAD_C0DE;
        m_split = 0; m_dfsr = 0; m_far = 0; m_pid = 0; m_ctx = 0; m_thr = 0;
    endtask

    function automatic logic [31:0] model_read(input int n, input int o);
        case (n)
            0:  return (o == 0) ? CORE_ID : (o == 1) ? CTYPE : 32'h0;
            1:  return (o == 0) ? m_ctrl : (o == 1) ? m_aux : (o == 2) ? m_cpacc : 32'h0;
            2:  return (o == 0) ? m_ttb0 : (o == 1) ? m_ttb1 : (o == 2) ? {29'h0, m_split} : 32'h0;
            3:  return m_dom;
            5:  return (o == 0) ? {24'h0, m_dfsr} : 32'h0;
            6:  return m_far;
            13: return (o == 0) ? m_pid : (o == 1) ? m_ctx : (o == 3) ? m_thr : 32'h0;
            default: return 32'h0;
        endcase
    endfunction

    // returns 1 when the write is refused
    function automatic bit model_write(input int n, input int m, input int o, input logic [31:0] v);
        case (n)
            1: begin
                if (o == 0) m_ctrl = (v | FSET) & ~FCLR;
                else if (o == 1) m_aux = v;
                else if (o == 2) m_cpacc = v;
                else return 1;
            end
            2: begin
                if (o == 0) m_ttb0 = v;
                else if (o == 1) m_ttb1 = v;
                else if (o == 2) m_split = v[2:0];
                else return 1;
            end
            3: m_dom = v;
            5: begin
                if (o == 0) m_dfsr = v[7:0];
                else return 1;
            end
            6: m_far = v;
            7, 9, 10: ;
            8: if (!((m >= 5) && (m <= 7) && (o <= 2))) return 1;
            13: begin
                if (o == 0) m_pid = v;
                else if (o == 1) m_ctx = v;
                else if (o == 3) m_thr = v;
                else return 1;
            end
            default: return 1;
        endcase
        return 0;
    endfunction

    task automatic do_read(input int n, input int o, input string req);
        @(negedge clk);
        rd_en = 1; crn = n[3:0]; op2 = o[2:0];
        @(negedge clk);
        rd_en = 0;
        check({req, " rvalid"}, {31'h0, rvalid}, 32'h1);
        check({req, " rdata"}, rdata, model_read(n, o));
    endtask

    task automatic do_write(input int n, input int m, input int o, input logic [31:0] v, input string req);
        bit e;
        e = model_write(n, m, o, v);
        @(negedge clk);
        wr_en = 1; crn = n[3:0]; crm = m[3:0]; op2 = o[2:0]; wdata = v;
        @(negedge clk);
        wr_en = 0;
        check({req, " wr_ack"}, {31'h0, wr_ack}, {31'h0, !e});
        check({req, " wr_err"}, {31'h0, wr_err}, {31'h0, e});
    endtask

    task automatic read_all(input string req);
        for (int n = 0; n < 16; n++)
            for (int o = 0; o < 8; o++)
                do_read(n, o, req);
    endtask

    task automatic check_walker(input string req);
        check({req, " ctrl_o"}, ctrl_o, m_ctrl);
        check({req, " ttb0_o"}, ttb0_o, m_ttb0);
        check({req, " ttb1_o"}, ttb1_o, m_ttb1);
        check({req, " split_o"}, {29'h0, split_o}, {29'h0, m_split});
        check({req, " domain_o"}, domain_o, m_dom);
        check({req, " ctx_id_o"}, ctx_id_o, m_ctx);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state on walker outputs and strobes
        check_walker("R1");
        check("R1 idle strobes", {29'h0, rvalid, wr_ack, wr_err}, 32'h0);
        // R1, R7, R9: read sweep after reset
        read_all("R1_R7_R9 reset sweep");

        // R2: control forcing on two complementary patterns
        do_write(1, 0, 0, 32'h0000_0000, "R2 ctrl zeros");
        check_walker("R2 zeros R13");
        do_read(1, 0, "R2 ctrl zeros");
        do_write(1, 0, 0, 32'hFFFF_FFFF, "R2 ctrl ones");
        do_read(1, 0, "R2 ctrl ones");
        check("R2 ctrl ones value", ctrl_o, 32'hFFFF_FBFF);

        // R3..R11: sweep every primary/opcode2 write, read all back
        for (int n = 0; n < 16; n++)
            for (int o = 0; o < 8; o++) begin
                logic [31:0] v;
                v = 32'h5A3C_96E1 ^ {n[3:0], 4'h0, n[3:0], 4'h0, 5'h0, o[2:0], 5'h0, o[2:0]};
                do_write(n, 5, o, v, "R3_R4_R5_R6_R8_R10_R11 write");
                check_walker("R13 after write");
                read_all("R3_R4_R5_R6_R8_R9_R10 readback");
            end

        // R11: TLB maintenance secondary/opcode2 sweep
        for (int m = 0; m < 16; m++)
            for (int o = 0; o < 8; o++) begin
                do_write(8, m, o, 32'hFFFF_FFFF, "R11 tlb maint");
                check_walker("R11 no change");
            end
        read_all("R11 readback");

        // R12: both strobes at once -> write only
        begin
            bit e;
            e = model_write(13, 0, 1, 32'hC0FF_EE11);
            @(negedge clk);
            wr_en = 1; rd_en = 1; crn = 13; op2 = 1; wdata = 32'hC0FF_EE11;
            @(negedge clk);
            wr_en = 0; rd_en = 0;
            check("R12 rvalid low on collision", {31'h0, rvalid}, 32'h0);
            check("R12 wr_ack on collision", {31'h0, wr_ack}, {31'h0, !e});
            check("R13 ctx after collision", ctx_id_o, 32'hC0FF_EE11);
            @(negedge clk);
            check("R12 strobes one cycle", {29'h0, rvalid, wr_ack, wr_err}, 32'h0);
        end

        // R12: back-to-back reads
        @(negedge clk);
        rd_en = 1; crn = 0; op2 = 0;
        @(negedge clk);
        crn = 0; op2 = 1;
        check("R12 b2b first", rdata, CORE_ID);
        @(negedge clk);
        rd_en = 0;
        check("R12 b2b second", rdata, CTYPE);
        check("R12 b2b rvalid", {31'h0, rvalid}, 32'h1);
        @(negedge clk);
        check("R12 rvalid drops", {31'h0, rvalid}, 32'h0);

        // R1: reset again restores values
        rst_n = 0;
        model_reset();
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_walker("R1 second reset");
        read_all("R1 second reset sweep");

        finish_run();
    end

endmodule